// File: doc/BRIEF.md
# Serial Converter Word Reader

This block sits on the host side of a serial delta-sigma converter that returns each result as a 32-bit word. When asked to read, it pulls the chip select low and watches the data line. The converter shows its conversion state on that line: high while it is busy and low once a result is ready. The reader keeps checking the line until it reads low. It then runs 32 serial clock pulses, samples one bit on each rising edge, and splits the captured word into its fields.

The word comes in most significant bit first. Bit 31 is the busy flag. Bit 30 gives the input channel and bit 29 the polarity. Bits 28 to 5 hold the 24-bit result and bits 4 to 0 hold the extra fine bits. The polarity bit and the top result bit together show whether the input went past either end of the scale. The reader turns that pair into over-range and under-range flags and a saturated two's-complement value.

The serial clock half-period and the spacing between data-line checks are parameters, both counted in system clocks. Each request produces one word and ends with a one-cycle result strobe. If the word was captured while the converter was still busy, the reader raises an error strobe instead.

Top module: `adc_word_reader`

## Requirements
- R1: After reset, and while reset is held, `cs_n_o` is high, `sck_o` is low, and `valid_o` and `err_o` are low.
- R2: When `start_i` is high in idle, `cs_n_o` goes low. `sck_o` stays low while the reader samples `sdo_i`, first after `HALF_DIV` clocks and then every `POLL_DIV` clocks for as long as the sampled value is 1. Clocking begins only after a 0 is sampled.
- R3: Each high phase and each low phase of `sck_o` lasts exactly `HALF_DIV` clocks. The first rising edge comes at least `HALF_DIV` clocks after `cs_n_o` falls.
- R4: `sck_o` is low whenever `cs_n_o` is high. Each read makes exactly 32 rising edges. `sdo_i` is sampled on each rising edge, and the first sample is word bit 31.
- R5: `chan_o` equals word bit 30, and `sub_lsb_o` equals word bits 4 to 0.
- R6: When bit 29 differs from bit 28, `result_o` equals bits 28 to 5, read as a 24-bit two's-complement number. Bit 29 = 1 gives a value of zero or more; bit 29 = 0 gives a negative value.
- R7: When bits 29 and 28 are both 1, `over_o` is 1, `under_o` is 0 and `result_o` is 24'h7FFFFF.
- R8: When bits 29 and 28 are both 0, `under_o` is 1, `over_o` is 0 and `result_o` is 24'h800000.
- R9: One clock after the falling edge that follows the 32nd rising edge, `cs_n_o` goes high and `valid_o` is high for exactly that one cycle.
- R10: If captured bit 31 is 1, `err_o` pulses for one cycle in place of `valid_o`, and the decoded outputs keep their previous values.
- R11: A `start_i` that arrives while a read is in progress is ignored. After the read ends, the reader stays idle with `cs_n_o` high until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Read request, taken only in idle |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sck_o | output | 1 | Serial clock, idles low |
| valid_o | output | 1 | One-cycle strobe for a good word |
| err_o | output | 1 | One-cycle strobe for a word captured while busy |
| chan_o | output | 1 | Channel bit of the last good word |
| result_o | output | 24 | Signed, saturated result |
| sub_lsb_o | output | 5 | Fine bits below the 24-bit result |
| over_o | output | 1 | Input above positive full scale |
| under_o | output | 1 | Input below negative full scale |

## Verification
The checks assume that `start_i` is synchronous to `clk_i`. They also assume that the converter changes `sdo_i` only on falling edges of `sck_o` or while polling, so the value is steady for `HALF_DIV` clocks before every rising edge.

The bench's converter model follows these rules. It shows its busy level until the first falling edge, then the word bits on each following falling edge, and a constant high while chip select is released.

The error case is the one deliberate exception. There the model raises its busy level between the poll sample and the first rising edge.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  // Word layout; the positions below are decoded by the reader.
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SUB_W    = 5;
  localparam int unsigned RES_W    = 24;
  localparam int unsigned FLAG_BIT = WORD_W - 1;
  localparam int unsigned CHAN_BIT = WORD_W - 2;
  localparam int unsigned SIGN_BIT = WORD_W - 3;
  localparam int unsigned MAG_HI   = WORD_W - 4;
  localparam int unsigned MAG_LO   = SUB_W;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_WAIT,
    RD_SHIFT,
    RD_DONE
  } rd_state_e;

  typedef struct packed {
    logic             busy_flag;
    logic             chan;
    logic             over;
    logic             under;
    logic [RES_W-1:0] value;
    logic [SUB_W-1:0] sub;
  } rd_fields_t;

endpackage

// File: rtl/adc_rd_sck_gen.sv
module adc_rd_sck_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sck_q, sck_d;
  logic          tick;

  assign tick = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run_i) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck_o  = sck_q;
  assign rise_o = tick & ~sck_q;
  assign fall_o = tick &  sck_q;

  AST_SCK_PARKS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sck_o); // R4

  AST_EDGE_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && (sck_o != $past(sck_o)) |-> $past(cnt_q) == CW'(HALF_DIV - 1)); // R3

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);

  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              en;

  assign en = clear_i | shift_i;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (clear_i) begin
      word_d = '0;
      cnt_d  = '0;
    end else if (shift_i) begin
      word_d = {word_q[WORD_W-2:0], bit_i};
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

  assign word_o = word_q;
  assign full_o = (cnt_q == CNT_W'(WORD_W));

  AST_NO_SHIFT_PAST_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !full_o); // R4

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WORD_W)); // R4

endmodule

// File: rtl/adc_rd_decode.sv
module adc_rd_decode
  import adc_rd_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output rd_fields_t        fields_o
);

  logic sign_b, top_b;

  assign sign_b = word_i[SIGN_BIT];
  assign top_b  = word_i[MAG_HI];

  always_comb begin
    fields_o.busy_flag = word_i[FLAG_BIT];
    fields_o.chan      = word_i[CHAN_BIT];
    fields_o.sub       = word_i[SUB_W-1:0];
    fields_o.over      = sign_b & top_b;
    fields_o.under     = ~sign_b & ~top_b;
    if (sign_b & top_b) begin
      fields_o.value = {1'b0, {(RES_W-1){1'b1}}};
    end else if (~sign_b & ~top_b) begin
      fields_o.value = {1'b1, {(RES_W-1){1'b0}}};
    end else begin
      fields_o.value = word_i[MAG_HI:MAG_LO];
    end
  end

endmodule

// File: rtl/adc_word_reader.sv
module adc_word_reader
  import adc_rd_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned POLL_DIV = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sdo_i,
  output logic             cs_n_o,
  output logic             sck_o,
  output logic             valid_o,
  output logic             err_o,
  output logic             chan_o,
  output logic [RES_W-1:0] result_o,
  output logic [SUB_W-1:0] sub_lsb_o,
  output logic             over_o,
  output logic             under_o
);

  localparam int unsigned WAIT_MAX = (HALF_DIV > POLL_DIV) ? HALF_DIV : POLL_DIV;
  localparam int unsigned WAIT_W   = (WAIT_MAX > 1) ? $clog2(WAIT_MAX) : 1;

  rd_state_e         state_q, state_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              cs_n_q, cs_n_d;
  logic              valid_q, valid_d;
  logic              err_q, err_d;
  logic              clear_sr, load_ok;
  logic              sck_run, sck_rise, sck_fall;
  logic              sr_full;
  logic [WORD_W-1:0] word;
  rd_fields_t        dec, fields_q;

  assign sck_run = (state_q == RD_SHIFT);

  adc_rd_sck_gen #(
    .HALF_DIV(HALF_DIV)
  ) u_sck (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (sck_run),
    .sck_o (sck_o),
    .rise_o(sck_rise),
    .fall_o(sck_fall)
  );

  adc_rd_shifter #(
    .WORD_W(WORD_W)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_sr),
    .shift_i(sck_rise),
    .bit_i  (sdo_i),
    .word_o (word),
    .full_o (sr_full)
  );

  adc_rd_decode u_dec (
    .word_i  (word),
    .fields_o(dec)
  );

  always_comb begin
    state_d  = state_q;
    wait_d   = wait_q;
    cs_n_d   = cs_n_q;
    valid_d  = 1'b0;
    err_d    = 1'b0;
    clear_sr = 1'b0;
    load_ok  = 1'b0;
    case (state_q)
      RD_IDLE: begin
        if (start_i) begin
          state_d  = RD_WAIT;
          cs_n_d   = 1'b0;
          wait_d   = WAIT_W'(HALF_DIV - 1);
          clear_sr = 1'b1;
        end
      end
      RD_WAIT: begin
        if (wait_q != '0) begin
          wait_d = wait_q - 1'b1;
        end else if (!sdo_i) begin
          state_d = RD_SHIFT;
        end else begin
          wait_d = WAIT_W'(POLL_DIV - 1);
        end
      end
      RD_SHIFT: begin
        if (sck_fall && sr_full) begin
          state_d = RD_DONE;
        end
      end
      RD_DONE: begin
        state_d = RD_IDLE;
        cs_n_d  = 1'b1;
        valid_d = ~dec.busy_flag;
        err_d   = dec.busy_flag;
        load_ok = ~dec.busy_flag;
      end
      default: begin
        state_d = RD_IDLE;
        cs_n_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      wait_q  <= '0;
      cs_n_q  <= 1'b1;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      cs_n_q  <= cs_n_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fields_q <= '0;
    end else if (load_ok) begin
      fields_q <= dec;
    end
  end

  assign cs_n_o    = cs_n_q;
  assign valid_o   = valid_q;
  assign err_o     = err_q;
  assign chan_o    = fields_q.chan;
  assign result_o  = fields_q.value;
  assign sub_lsb_o = fields_q.sub;
  assign over_o    = fields_q.over;
  assign under_o   = fields_q.under;

  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sck_o); // R4

  AST_NO_SCK_WHILE_POLLING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == RD_WAIT |-> !sck_o && !cs_n_o); // R2

  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R9

  AST_VALID_WITH_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(cs_n_o)); // R9

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !valid_o && $stable(result_o)); // R10

  AST_RANGE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(over_o && under_o)); // R7

  AST_START_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RD_SHIFT) && start_i |=> state_q != RD_WAIT); // R11

endmodule

// File: tb/test_adc_word_reader.sv
module test_adc_word_reader;

  localparam int unsigned HALF_DIV = 4;
  localparam int unsigned POLL_DIV = 8;
  localparam int NVEC = 8;

  // {chan, sign, magnitude[23:0], sub[4:0], busy clocks[5:0]}
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 24'h123456, 5'h15, 6'd0},
    {1'b1, 1'b1, 24'h000000, 5'h00, 6'd20},
    {1'b0, 1'b0, 24'hFEDCBA, 5'h1F, 6'd5},
    {1'b1, 1'b1, 24'hC00000, 5'h0A, 6'd3},
    {1'b0, 1'b0, 24'h3FFFFF, 5'h11, 6'd40},
    {1'b1, 1'b0, 24'h800000, 5'h01, 6'd0},
    {1'b0, 1'b1, 24'h7FFFFF, 5'h1E, 6'd7},
    {1'b1, 1'b0, 24'hFFFFFF, 5'h04, 6'd12}
  };

  logic        clk, rst_n, start;
  logic        sdo, cs_n, sck, valid, err, chan, over, under;
  logic [23:0] result;
  logic [4:0]  sub;

  int n_chk  = 0;
  int n_fail = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  adc_word_reader #(
    .HALF_DIV(HALF_DIV),
    .POLL_DIV(POLL_DIV)
  ) i_adc_word_reader (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .sdo_i    (sdo),
    .cs_n_o   (cs_n),
    .sck_o    (sck),
    .valid_o  (valid),
    .err_o    (err),
    .chan_o   (chan),
    .result_o (result),
    .sub_lsb_o(sub),
    .over_o   (over),
    .under_o  (under)
  );

  // Converter model
  logic [31:0] mword;
  logic        eoc_lvl;
  int          fall_cnt;

  always @(negedge sck or posedge cs_n) begin
    if (cs_n) fall_cnt <= 0;
    else      fall_cnt <= fall_cnt + 1;
  end

  always_comb begin
    if (cs_n)               sdo = 1'b1;
    else if (fall_cnt == 0) sdo = eoc_lvl;
    else if (fall_cnt >= 32) sdo = 1'b1;
    else                    sdo = mword[31 - fall_cnt];
  end

  // Edge monitor
  int  cyc = 0, cs_fall_cyc = 0, first_gap = 0, last_edge = -1;
  int  rises = 0, gap_bad = 0, early = 0;
  logic sck_p = 1'b0, cs_p = 1'b1;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cs_p && !cs_n) begin
      cs_fall_cyc <= cyc;
      rises <= 0; gap_bad <= 0; early <= 0; last_edge <= -1;
    end else if (sck != sck_p) begin
      if (last_edge >= 0 && (cyc - last_edge) != HALF_DIV) gap_bad <= gap_bad + 1;
      last_edge <= cyc;
      if (sck) begin
        rises <= rises + 1;
        if (rises == 0) first_gap <= cyc - cs_fall_cyc;
        if (eoc_lvl) early <= early + 1;
      end
    end
    sck_p <= sck;
    cs_p  <= cs_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_end(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (valid || err) seen = 1'b1;
    end
  endtask

  task automatic do_word(input logic ch, input logic sg, input logic [23:0] mg,
                         input logic [4:0] sb, input int busy);
    bit          seen;
    logic        x_over, x_under;
    logic [23:0] x_val;
    mword   = {1'b0, ch, sg, mg, sb};
    eoc_lvl = 1'b1;
    pulse_start();
    repeat (busy) @(negedge clk);
    eoc_lvl = 1'b0;
    wait_end(seen);
    x_over  = sg & mg[23];
    x_under = ~sg & ~mg[23];
    x_val   = x_over ? 24'h7FFFFF : (x_under ? 24'h800000 : mg);
    chk("R9 valid strobe", {31'd0, seen & valid}, 32'd1);
    chk("R9 cs released at strobe", {31'd0, cs_n}, 32'd1);
    chk("R10 no error on ready word", {31'd0, err}, 32'd0);
    chk("R5 channel", {31'd0, chan}, {31'd0, ch});
    chk("R5 sub bits", {27'd0, sub}, {27'd0, sb});
    if (x_over)       chk("R7 saturated high", {8'd0, result}, {8'd0, x_val});
    else if (x_under) chk("R8 saturated low", {8'd0, result}, {8'd0, x_val});
    else              chk("R6 result", {8'd0, result}, {8'd0, x_val});
    chk("R7 over flag", {31'd0, over}, {31'd0, x_over});
    chk("R8 under flag", {31'd0, under}, {31'd0, x_under});
    chk("R4 rising edges", rises, 32);
    chk("R3 half period", gap_bad, 0);
    chk("R3 select lead", {31'd0, first_gap >= HALF_DIV}, 32'd1);
    chk("R2 no clock before ready", early, 0);
    @(negedge clk);
    chk("R9 strobe one cycle", {31'd0, valid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    bit          seen;
    int          lows;
    logic [23:0] keep;
    start = 1'b0; eoc_lvl = 1'b0; mword = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset cs", {31'd0, cs_n}, 32'd1);
    chk("R1 reset sck", {31'd0, sck}, 32'd0);
    chk("R1 reset strobes", {30'd0, valid, err}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      do_word(VEC[v][36], VEC[v][35], VEC[v][34:11], VEC[v][10:6], int'(VEC[v][5:0]));
      repeat (3) @(negedge clk);
    end

    // Random words on both channels
    for (int k = 0; k < 8; k++) begin
      do_word(k[0], 1'($urandom), 24'($urandom), 5'($urandom), int'($urandom_range(0, 30)));
      repeat (2) @(negedge clk);
    end

    // R10: word captured while busy
    keep    = result;
    mword   = {1'b0, 1'b1, 1'b1, 24'h000055, 5'h00};
    eoc_lvl = 1'b0;
    pulse_start();
    repeat (5) @(negedge clk);
    eoc_lvl = 1'b1;
    wait_end(seen);
    chk("R10 error strobe", {30'd0, seen & err, valid}, 32'd2);
    chk("R10 result held", {8'd0, result}, {8'd0, keep});
    eoc_lvl = 1'b0;
    @(negedge clk);
    chk("R10 error one cycle", {31'd0, err}, 32'd0);
    repeat (3) @(negedge clk);

    // R11: request during a read is dropped
    mword   = {1'b0, 1'b0, 1'b1, 24'h0ABCDE, 5'h03};
    eoc_lvl = 1'b1;
    pulse_start();
    repeat (6) @(negedge clk);
    eoc_lvl = 1'b0;
    repeat (40) @(negedge clk);
    pulse_start();
    wait_end(seen);
    chk("R11 read completes", {31'd0, seen & valid}, 32'd1);
    chk("R11 result", {8'd0, result}, 32'h000ABCDE);
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!cs_n) lows++;
    end
    chk("R11 stays idle", lows, 0);

    // R1: reset in the middle of clocking
    mword   = {1'b0, 1'b1, 1'b1, 24'h111111, 5'h00};
    eoc_lvl = 1'b0;
    pulse_start();
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset mid-read cs", {31'd0, cs_n}, 32'd1);
    chk("R1 reset mid-read sck", {31'd0, sck}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: long busy period still yields a good read
    do_word(1'b1, 1'b0, 24'hC0FFEE, 5'h1B, 63);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule